// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

The block holds a wall-clock time and date as packed BCD bytes (seconds, minutes, hours, weekday, day of month, month, two-digit year and century) and moves it forward by one second each time an accepted one-second tick arrives. Every advance runs through a short update window. A readable update-in-progress flag is high for the whole window. The new time is committed at the end of the window, and a one-cycle done pulse marks the commit. The rollover follows the full Gregorian calendar, including the rule that a century year is a leap year only when it is divisible by 400.

Software reaches the state through a flat byte-wide register port: an address, write data, a write strobe and a combinational read bus. A 3-bit divider code in control register A must hold the run value before ticks are accepted. A set bit in control register B freezes the counter so that new time values can be loaded without being overwritten. Writing the set bit also cancels any update that is in flight.

Top module: `rtc_calendar`

## Requirements
- R1: Register map: 0 seconds, 1 minutes, 2 hours (00-23), 3 weekday (1-7), 4 day of month, 5 month (1-12), 6 year (00-99), 7 century, 8 control A, 9 control B. All time values are BCD. Any other address reads 0x00.
- R2: Seconds wrap 59 to 00 with a carry into minutes. Minutes wrap 59 to 00 with a carry into hours. Hours wrap 23 to 00 and produce a day carry.
- R3: On a day carry the weekday advances, and it returns from 7 to 1.
- R4: On a day carry the day of month advances. After the month's last day it returns to 1 and the month advances. Month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. Month 12 wraps to 1 and advances the year. Year 99 wraps to 00 and advances the century.
- R5: February has 29 days when the full year (century*100+year) is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28.
- R6: A tick is accepted only when control A bits 6:4 equal 3'b010. With any other code, ticks are ignored: there is no done pulse and the time is unchanged.
- R7: While control B bit 7 (set) is 1, ticks are ignored and written time values stay as written.
- R8: A write to control B with bit 7 = 1 stores bit 4 as 0, clears the update-in-progress flag (control A bit 7), and cancels any pending commit without a done pulse.
- R9: An accepted tick raises control A bit 7 from the next cycle for UPD_CYCLES cycles. When the flag falls, the advanced time becomes visible and upd_done_o is high for exactly one cycle.
- R10: A tick that arrives while an update is in progress is ignored.
- R11: A day of month at or above the month's length becomes 1 on the next day carry, and the month advances.
- R12: After reset the time reads 20 00-01-01, weekday 1, 00:00:00. Control A reads 0x20 and control B reads 0x00. Control A bit 7 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tick_i | input | 1 | One-second tick, one cycle wide |
| upd_done_o | output | 1 | One-cycle pulse on each committed update |

## Verification
The checker watches the update window on every cycle. It checks that a window opens only from a tick with the run code and set clear, that the done pulse lasts one cycle and closes a window of exactly UPD_CYCLES cycles, and that set mode keeps the flag and the done pulse low. It also checks that a set write cancels the window and that seconds change only on a commit or a write. The calendar arithmetic is shown only by the bench's scenarios: carries, month lengths, leap and century years, and forcing an out-of-range day back to 1. The same holds for ticks that are dropped while the divider code is wrong or an update is running.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NT = 8;

  localparam int unsigned T_SEC  = 0;
  localparam int unsigned T_MIN  = 1;
  localparam int unsigned T_HOUR = 2;
  localparam int unsigned T_WDAY = 3;
  localparam int unsigned T_MDAY = 4;
  localparam int unsigned T_MON  = 5;
  localparam int unsigned T_YEAR = 6;
  localparam int unsigned T_CENT = 7;

  localparam int unsigned A_CTRL_A = 8;
  localparam int unsigned A_CTRL_B = 9;

  localparam logic [2:0] DIV_RUN = 3'b010;
  localparam int unsigned B_SET_BIT = 7;
  localparam int unsigned B_UEI_BIT = 4;

  typedef logic [NT-1:0][DW-1:0] tm_t;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
(
  input  logic [7:0] cur_i,
  input  logic [7:0] hi_i,
  input  logic [7:0] lo_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o
);
  logic [7:0] bin;
  logic [7:0] nbin;

  always_comb begin
    bin  = bcd2bin(cur_i);
    nbin = (bin >= hi_i) ? lo_i : bin + 8'd1;
    nxt_o = inc_i ? bin2bcd(nbin) : cur_i;
  end
endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_pkg::*;
(
  input  tm_t cur_i,
  output tm_t nxt_o
);
  logic [7:0] yb, cb, mb, mlen;
  logic       leap;
  logic [NT-1:0]       inc;
  logic [NT-1:0][7:0]  hi;
  logic [NT-1:0][7:0]  lo;

  always_comb begin
    yb   = bcd2bin(cur_i[T_YEAR]);
    cb   = bcd2bin(cur_i[T_CENT]);
    mb   = bcd2bin(cur_i[T_MON]);
    leap = (yb[1:0] == 2'b00) && ((yb != 8'd0) || (cb[1:0] == 2'b00));
    case (mb)
      8'd2:                    mlen = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: mlen = 8'd30;
      default:                 mlen = 8'd31;
    endcase

    hi[T_SEC]  = 8'd59; lo[T_SEC]  = 8'd0;
    hi[T_MIN]  = 8'd59; lo[T_MIN]  = 8'd0;
    hi[T_HOUR] = 8'd23; lo[T_HOUR] = 8'd0;
    hi[T_WDAY] = 8'd7;  lo[T_WDAY] = 8'd1;
    hi[T_MDAY] = mlen;  lo[T_MDAY] = 8'd1;
    hi[T_MON]  = 8'd12; lo[T_MON]  = 8'd1;
    hi[T_YEAR] = 8'd99; lo[T_YEAR] = 8'd0;
    hi[T_CENT] = 8'd99; lo[T_CENT] = 8'd0;

    // carry chain: weekday and day of month share the day carry
    inc[T_SEC]  = 1'b1;
    inc[T_MIN]  = bcd2bin(cur_i[T_SEC])  >= hi[T_SEC];
    inc[T_HOUR] = inc[T_MIN]  && (bcd2bin(cur_i[T_MIN])  >= hi[T_MIN]);
    inc[T_WDAY] = inc[T_HOUR] && (bcd2bin(cur_i[T_HOUR]) >= hi[T_HOUR]);
    inc[T_MDAY] = inc[T_WDAY];
    inc[T_MON]  = inc[T_MDAY] && (bcd2bin(cur_i[T_MDAY]) >= mlen);
    inc[T_YEAR] = inc[T_MON]  && (mb >= hi[T_MON]);
    inc[T_CENT] = inc[T_YEAR] && (yb >= hi[T_YEAR]);
  end

  for (genvar g = 0; g < NT; g++) begin : g_field
    rtc_bcd_field u_field (
      .cur_i (cur_i[g]),
      .hi_i  (hi[g]),
      .lo_i  (lo[g]),
      .inc_i (inc[g]),
      .nxt_o (nxt_o[g])
    );
  end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int unsigned UPD_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_ok_i,
  input  logic abort_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int unsigned CW = (UPD_CYCLES > 1) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (tick_i && run_ok_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == LAST) && !abort_i;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned UPD_CYCLES  = 8,
  parameter logic [7:0]  RST_CENTURY = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  output logic              upd_done_o
);
  tm_t        tm_q, tm_d, tm_nxt;
  logic [2:0] div_q;
  logic [3:0] a_low_q;
  logic [7:0] b_q;
  logic       busy, commit, done_q;
  logic       wr_time, wr_a, wr_b, set_wr, run_ok;

  always_comb begin
    wr_time = we_i && (addr_i < ADDR_W'(NT));
    wr_a    = we_i && (addr_i == ADDR_W'(A_CTRL_A));
    wr_b    = we_i && (addr_i == ADDR_W'(A_CTRL_B));
    set_wr  = wr_b && wdata_i[B_SET_BIT];
    run_ok  = (div_q == DIV_RUN) && !b_q[B_SET_BIT];
  end

  rtc_update_seq #(.UPD_CYCLES(UPD_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_ok_i (run_ok),
    .abort_i  (set_wr),
    .busy_o   (busy),
    .commit_o (commit)
  );

  rtc_calendar_next u_next (
    .cur_i (tm_q),
    .nxt_o (tm_nxt)
  );

  // a register write in the commit cycle wins over the advanced value
  always_comb begin
    tm_d = commit ? tm_nxt : tm_q;
    if (wr_time) tm_d[addr_i[2:0]] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tm_q         <= '0;
      tm_q[T_WDAY] <= 8'h01;
      tm_q[T_MDAY] <= 8'h01;
      tm_q[T_MON]  <= 8'h01;
      tm_q[T_CENT] <= RST_CENTURY;
      div_q        <= DIV_RUN;
      a_low_q      <= '0;
      b_q          <= '0;
      done_q       <= 1'b0;
    end else begin
      tm_q   <= tm_d;
      done_q <= commit;
      if (wr_a) begin
        div_q   <= wdata_i[6:4];
        a_low_q <= wdata_i[3:0];
      end
      if (wr_b) begin
        b_q <= wdata_i;
        if (set_wr) b_q[B_UEI_BIT] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (addr_i < ADDR_W'(NT))             rdata_o = tm_q[addr_i[2:0]];
    else if (addr_i == ADDR_W'(A_CTRL_A)) rdata_o = {busy, div_q, a_low_q};
    else if (addr_i == ADDR_W'(A_CTRL_B)) rdata_o = b_q;
    else                                  rdata_o = '0;
  end

  assign upd_done_o = done_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned UPD_CYCLES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              set_i,
  input logic [2:0]        div_i,
  input logic [7:0]        sec_i
);
  localparam int unsigned WW = $clog2(UPD_CYCLES + 2) + 1;
  logic [WW-1:0] win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     win_cnt <= '0;
    else if (busy_i) win_cnt <= win_cnt + 1'b1;
    else             win_cnt <= '0;
  end

  AST_DONE_ENDS_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ($past(busy_i) && !busy_i)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R9
  AST_WINDOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (win_cnt == WW'(UPD_CYCLES))); // R9
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(tick_i) && ($past(div_i) == 3'b010) && !$past(set_i))); // R6
  AST_SET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> (!busy_i && !done_i)); // R7
  AST_SET_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == ADDR_W'(9)) && wdata_i[7]) |=> (!busy_i && !done_i)); // R8
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_i) |-> (done_i || $past(we_i && (addr_i == '0)))); // R7
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W), .UPD_CYCLES(UPD_CYCLES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .busy_i  (busy),
  .done_i  (upd_done_o),
  .set_i   (b_q[7]),
  .div_i   (div_q),
  .sec_i   (tm_q[0])
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned UPD    = 8;
  localparam int unsigned NV     = 16;

  // {start, expected, requirement}; bytes: cent year mon mday wday hour min sec
  localparam logic [135:0] VEC [NV] = '{
    {64'h20000101_01000000, 64'h20000101_01000001, 8'd2},  // R2 second
    {64'h20240615_03123459, 64'h20240615_03123500, 8'd2},  // R2 minute carry
    {64'h20240615_03125959, 64'h20240615_03130000, 8'd2},  // R2 hour carry
    {64'h20240315_07235959, 64'h20240316_01000000, 8'd3},  // R3 weekday 7->1
    {64'h20240131_03235959, 64'h20240201_04000000, 8'd4},  // R4 31-day month
    {64'h20230228_02235959, 64'h20230301_03000000, 8'd5},  // R5 2023 not leap
    {64'h20240228_03235959, 64'h20240229_04000000, 8'd5},  // R5 2024 leap
    {64'h20240229_04235959, 64'h20240301_05000000, 8'd5},  // R5 end of Feb 29
    {64'h21000228_07235959, 64'h21000301_01000000, 8'd5},  // R5 2100 not leap
    {64'h20000228_01235959, 64'h20000229_02000000, 8'd5},  // R5 2000 leap
    {64'h20240430_02235959, 64'h20240501_03000000, 8'd4},  // R4 30-day month
    {64'h20991231_05235959, 64'h21000101_06000000, 8'd4},  // R4 century carry
    {64'h19991231_06235959, 64'h20000101_07000000, 8'd4},  // R4 year carry
    {64'h20240635_01235959, 64'h20240701_02000000, 8'd11}, // R11 bad day
    {64'h20240930_01235959, 64'h20241001_02000000, 8'd4},  // R4 September
    {64'h20241130_01235959, 64'h20241201_02000000, 8'd4}   // R4 November
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic              we = 1'b0;
  logic              tick = 1'b0;
  logic [7:0]        rdata;
  logic              done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  rtc_calendar #(.ADDR_W(ADDR_W), .UPD_CYCLES(UPD)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .addr_i (addr), .wdata_i (wdata),
    .we_i (we), .rdata_o (rdata), .tick_i (tick), .upd_done_o (done)
  );

  always @(negedge clk) if (rst_ni && done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = ADDR_W'(a);
    #0.5;
    d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(i, b);
      t[8*i +: 8] = b;
    end
  endtask

  task automatic load_time(input logic [63:0] t);
    for (int i = 0; i < 8; i++) wr(i, t[8*i +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] t;
    logic [7:0]  b;
    int          d0;
    int          seen;

    wait_cycles(3);
    rst_ni = 1'b1;
    wait_cycles(1);

    // R12 reset state
    read_time(t);
    chk(t == 64'h20000101_01000000, "R12 reset time", t, 64'h20000101_01000000);
    rd(8, b); chk(b == 8'h20, "R12 reset ctrl A", 64'(b), 64'h20);
    rd(9, b); chk(b == 8'h00, "R12 reset ctrl B", 64'(b), 64'h00);

    // R1 unmapped address reads zero, R12 flag bit read-only
    rd(12, b); chk(b == 8'h00, "R1 unmapped read", 64'(b), 64'h00);
    wr(8, 8'hA0);
    rd(8, b); chk(b == 8'h20, "R12 UIP read-only", 64'(b), 64'h20);

    // vector table: calendar advance
    for (int v = 0; v < NV; v++) begin
      load_time(VEC[v][135:72]);
      d0 = done_cnt;
      pulse_tick();
      wait_cycles(UPD + 3);
      read_time(t);
      chk((t == VEC[v][71:8]) && (done_cnt == d0 + 1),
          $sformatf("R%0d vector %0d", VEC[v][7:0], v), t, VEC[v][71:8]);
    end

    // R9 window timing
    load_time(64'h20240615_03120000);
    d0 = done_cnt;
    pulse_tick();
    addr = ADDR_W'(8);
    seen = 0;
    #0.5;
    if (rdata[7] && !done) seen++;
    for (int k = 1; k < int'(UPD); k++) begin
      @(negedge clk); #0.5;
      if (rdata[7] && !done) seen++;
    end
    chk(seen == int'(UPD), "R9 UIP high for window", 64'(seen), 64'(UPD));
    @(negedge clk); #0.5;
    chk(done && !rdata[7], "R9 done as UIP falls", {62'd0, done, rdata[7]}, 64'h2);
    rd(0, b); chk(b == 8'h01, "R9 time at done", 64'(b), 64'h01);
    @(negedge clk); #0.5;
    chk(!done, "R9 done one cycle", 64'(done), 64'h0);

    // R10 second tick during window ignored
    load_time(64'h20240615_03120000);
    d0 = done_cnt;
    pulse_tick();
    wait_cycles(2);
    pulse_tick();
    wait_cycles(UPD + 6);
    rd(0, b);
    chk((b == 8'h01) && (done_cnt == d0 + 1), "R10 tick in window ignored", 64'(b), 64'h01);

    // R6 divider code gating
    wr(8, 8'h30);
    d0 = done_cnt;
    pulse_tick();
    wait_cycles(UPD + 4);
    rd(0, b);
    chk((b == 8'h01) && (done_cnt == d0), "R6 wrong divider holds", 64'(b), 64'h01);
    wr(8, 8'h20);
    pulse_tick();
    wait_cycles(UPD + 3);
    rd(0, b);
    chk((b == 8'h02) && (done_cnt == d0 + 1), "R6 run code advances", 64'(b), 64'h02);

    // R7 set mode freezes
    wr(9, 8'h80);
    wr(0, 8'h42);
    d0 = done_cnt;
    pulse_tick();
    wait_cycles(UPD + 4);
    rd(0, b);
    chk((b == 8'h42) && (done_cnt == d0), "R7 set mode holds", 64'(b), 64'h42);
    wr(9, 8'h00);

    // R8 set write aborts window and clears UEI
    wr(0, 8'h10);
    d0 = done_cnt;
    pulse_tick();
    wait_cycles(1);
    wr(9, 8'h90);
    rd(9, b); chk(b == 8'h80, "R8 UEI forced low", 64'(b), 64'h80);
    rd(8, b); chk(b[7] == 1'b0, "R8 UIP cleared", 64'(b), 64'h20);
    wait_cycles(UPD + 2);
    rd(0, b);
    chk((b == 8'h10) && (done_cnt == d0), "R8 aborted update", 64'(b), 64'h10);
    wr(9, 8'h1F);
    rd(9, b); chk(b == 8'h1F, "R8 UEI kept without set", 64'(b), 64'h1F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule